// File: doc/BRIEF.md
# DRAM Command Timing Enforcer

This block sits between a memory request scheduler and a DRAM command bus. It takes ACTIVATE, READ, WRITE and PRECHARGE requests for a few banks over a ready/valid handshake and holds them in a short queue. It releases each request as an issued-command strobe only when the bank's activate-to-column delay, the bank's precharge period and the command launch rate all allow it. Each issued READ produces a read-data-valid marker tCL clocks later. Each issued WRITE produces a write-data-enable marker CWL clocks later.

All latencies come from one of four preset speed-bin profiles. The launch mode is either one command per clock (1N) or one per two clocks (2N). The profile and the mode are captured once, in the single configuration state that follows reset. The control state machine has three states:

- ST_CFG, entered on reset. Configuration is latched here and requests are refused.
- ST_OPEN. A queued request may be issued or rejected.
- ST_GAP. Used only in 2N mode; nothing is selected.

The transitions are:

- ST_CFG to ST_OPEN, always after one cycle.
- ST_OPEN to ST_GAP, on an issue while in 2N mode.
- ST_OPEN to ST_OPEN, otherwise.
- ST_GAP to ST_OPEN, always.

Top module: `dram_cmd_timer`

## Requirements
- R1: During reset and in the one ST_CFG cycle after reset release, req_ready_o is low. The profile select and launch mode are latched at the end of that cycle, and req_ready_o is high in the following cycle while the queue has room.
- R2: Profile select encodings, given as tCL/tRCD/tRP/CWL in clocks: 0 = 9/9/9/7, 1 = 11/11/11/8, 2 = 10/12/12/7, 3 = 12/15/15/8.
- R3: With cfg_2n_i=0, strobes may appear on consecutive cycles. With cfg_2n_i=1, every strobe cycle is followed by a cycle without a strobe.
- R4: A READ or WRITE strobe to a bank comes at least tRCD cycles after that bank's ACTIVATE strobe, and exactly tRCD when the column request was already waiting.
- R5: An ACTIVATE strobe to a bank comes at least tRP cycles after that bank's PRECHARGE strobe, and exactly tRP when it was waiting.
- R6: rd_data_valid_o is high exactly tCL cycles after each READ strobe. wr_data_en_o is high exactly CWL cycles after each WRITE strobe.
- R7: A READ or WRITE to a closed bank, or an ACTIVATE to an open bank, is removed from the queue with a one-cycle rej_o pulse. It gives no command strobe and no data marker. All banks are closed after reset, and PRECHARGE is always legal.
- R8: A request is taken when req_valid_i and req_ready_o are both high. req_cmd_i encodes 0 = ACTIVATE, 1 = READ, 2 = WRITE, 3 = PRECHARGE. The queue holds QDEPTH entries, and req_ready_o is low while it is full.
- R9: Of the queued requests that are legal this cycle, the oldest is taken. Requests to one bank keep their arrival order, and a request to another bank may overtake a waiting one.
- R10: Changing cfg_profile_i or cfg_2n_i after ST_CFG has no effect on spacing or latencies until the next reset.
- R11: During reset, cmd_valid_o, rej_o, rd_data_valid_o and wr_data_en_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_profile_i | input | 2 | Speed-bin profile select |
| cfg_2n_i | input | 1 | 1 selects one command per two clocks |
| req_valid_i | input | 1 | Scheduler request valid |
| req_ready_o | output | 1 | Block can take a request |
| req_cmd_i | input | 2 | Request command code |
| req_bank_i | input | BW | Request bank index |
| cmd_valid_o | output | 1 | Issued-command strobe |
| cmd_type_o | output | 2 | Issued command code |
| cmd_bank_o | output | BW | Issued command bank |
| rej_o | output | 1 | Request dropped as illegal |
| rd_data_valid_o | output | 1 | Read data expected this cycle |
| wr_data_en_o | output | 1 | Write data to be driven this cycle |

## Verification
The bench measures exact strobe-to-strobe and strobe-to-marker distances under every profile in both launch modes. A counter loaded one clock off would show up as a gap of tRCD±1 or tRP±1, and a mis-tapped delay line as a marker one cycle early or late. Directed cases cover several faults:
- A design that issues commands to a closed bank, or to an already open one, instead of pulsing the reject.
- A design that keeps a column request waiting behind another bank's request instead of letting that request go first.
- A design that follows the configuration pins after ST_CFG, which changes tRCD, tCL and the launch gap in mid-traffic.
- A design that keeps req_ready_o high while the queue is full.

// File: rtl/dct_pkg.sv
package dct_pkg;

    localparam int TW = 5;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } dct_cmd_e;

    typedef enum logic [1:0] {
        ST_CFG  = 2'd0,
        ST_OPEN = 2'd1,
        ST_GAP  = 2'd2
    } dct_state_e;

    typedef struct packed {
        logic [TW-1:0] tcl;
        logic [TW-1:0] trcd;
        logic [TW-1:0] trp;
        logic [TW-1:0] cwl;
    } dct_prof_t;

    // Speed-bin presets: low-voltage DDR3 at two rates, then LPDDR3 at two rates
    function automatic dct_prof_t dct_profile(input logic [1:0] sel);
        dct_prof_t p;
        unique case (sel)
            2'd0: begin p.tcl = 5'd9;  p.trcd = 5'd9;  p.trp = 5'd9;  p.cwl = 5'd7; end
            2'd1: begin p.tcl = 5'd11; p.trcd = 5'd11; p.trp = 5'd11; p.cwl = 5'd8; end
            2'd2: begin p.tcl = 5'd10; p.trcd = 5'd12; p.trp = 5'd12; p.cwl = 5'd7; end
            default: begin p.tcl = 5'd12; p.trcd = 5'd15; p.trp = 5'd15; p.cwl = 5'd8; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dct_bank_timer.sv
module dct_bank_timer
    import dct_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_i,
    input  logic          pre_i,
    input  logic [TW-1:0] trcd_i,
    input  logic [TW-1:0] trp_i,
    output logic          open_o,
    output logic          col_ok_o,
    output logic          act_ok_o
);

    logic          open_q;
    logic [TW-1:0] rcd_q;
    logic [TW-1:0] rp_q;

    // Counters are loaded with t-1 so that the legal check in the cycle
    // before an edge yields a strobe spacing of exactly t.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            rcd_q  <= '0;
            rp_q   <= '0;
        end else begin
            if (act_i) begin
                open_q <= 1'b1;
            end else if (pre_i) begin
                open_q <= 1'b0;
            end

            if (act_i) begin
                rcd_q <= trcd_i - TW'(1);
            end else if (rcd_q != '0) begin
                rcd_q <= rcd_q - TW'(1);
            end

            if (pre_i) begin
                rp_q <= trp_i - TW'(1);
            end else if (rp_q != '0) begin
                rp_q <= rp_q - TW'(1);
            end
        end
    end

    assign open_o   = open_q;
    assign col_ok_o = open_q && (rcd_q == '0);
    assign act_ok_o = !open_q && (rp_q == '0);

endmodule

// File: rtl/dct_lat_line.sv
module dct_lat_line #(
    parameter int MAXL = 16,
    parameter int LW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    input  logic [LW-1:0] lat_i,
    output logic          hit_o
);

    logic [MAXL:0] sr_q;
    logic [MAXL:0] ins;

    // A marker enters at position lat and reaches bit 0 lat cycles later
    always_comb begin
        for (int i = 0; i <= MAXL; i++) begin
            ins[i] = fire_i && (lat_i == LW'(i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= {1'b0, sr_q[MAXL:1]} | ins;
        end
    end

    assign hit_o = sr_q[0];

endmodule

// File: rtl/dct_req_queue.sv
module dct_req_queue #(
    parameter int DEPTH = 4,
    parameter int BW    = 2,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push_i,
    input  logic [1:0]                  push_cmd_i,
    input  logic [BW-1:0]               push_bank_i,
    input  logic                        pop_i,
    input  logic [IW-1:0]               pop_idx_i,
    output logic [CW-1:0]               cnt_o,
    output logic [DEPTH-1:0][1:0]       cmd_o,
    output logic [DEPTH-1:0][BW-1:0]    bank_o
);

    logic [CW-1:0]            cnt_q, cnt_mid, cnt_n;
    logic [DEPTH-1:0][1:0]    cmd_q, cmd_n;
    logic [DEPTH-1:0][BW-1:0] bank_q, bank_n;

    // Entry 0 is always the oldest; a pop closes the hole by shifting down
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int nx;
            nx = (i + 1 < DEPTH) ? i + 1 : i;
            if (pop_i && (IW'(i) >= pop_idx_i)) begin
                if (i == DEPTH - 1) begin
                    cmd_n[i]  = '0;
                    bank_n[i] = '0;
                end else begin
                    cmd_n[i]  = cmd_q[nx];
                    bank_n[i] = bank_q[nx];
                end
            end else begin
                cmd_n[i]  = cmd_q[i];
                bank_n[i] = bank_q[i];
            end
        end
        cnt_mid = cnt_q - (pop_i ? CW'(1) : CW'(0));
        if (push_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == cnt_mid) begin
                    cmd_n[i]  = push_cmd_i;
                    bank_n[i] = push_bank_i;
                end
            end
        end
        cnt_n = cnt_mid + (push_i ? CW'(1) : CW'(0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cmd_q  <= '0;
            bank_q <= '0;
        end else begin
            cnt_q  <= cnt_n;
            cmd_q  <= cmd_n;
            bank_q <= bank_n;
        end
    end

    assign cnt_o  = cnt_q;
    assign cmd_o  = cmd_q;
    assign bank_o = bank_q;

endmodule

// File: rtl/dram_cmd_timer.sv
module dram_cmd_timer
    import dct_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int QDEPTH    = 4,
    parameter int MAX_LAT   = 16,
    localparam int BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_profile_i,
    input  logic          cfg_2n_i,
    input  logic          req_valid_i,
    output logic          req_ready_o,
    input  logic [1:0]    req_cmd_i,
    input  logic [BW-1:0] req_bank_i,
    output logic          cmd_valid_o,
    output logic [1:0]    cmd_type_o,
    output logic [BW-1:0] cmd_bank_o,
    output logic          rej_o,
    output logic          rd_data_valid_o,
    output logic          wr_data_en_o
);

    localparam int CW = $clog2(QDEPTH + 1);
    localparam int IW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

    dct_state_e state_q, state_n;
    dct_prof_t  prof_q;
    logic       mode2n_q;

    logic [CW-1:0]             q_cnt;
    logic [QDEPTH-1:0][1:0]    q_cmd;
    logic [QDEPTH-1:0][BW-1:0] q_bank;

    logic [NUM_BANKS-1:0] bank_open, bank_col_ok, bank_act_ok;

    logic [QDEPTH-1:0] blocked_v, legal_v, bad_v, elig_v;
    logic              found;
    logic [IW-1:0]     sel_idx;
    dct_cmd_e          sel_cmd;
    logic [BW-1:0]     sel_bank;
    logic              sel_rej;
    logic              do_issue, do_rej;
    logic              push;

    // ---------------- request intake ----------------
    assign req_ready_o = (state_q != ST_CFG) && (q_cnt < CW'(QDEPTH));
    assign push        = req_valid_i && req_ready_o;

    dct_req_queue #(
        .DEPTH (QDEPTH),
        .BW    (BW)
    ) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_cmd_i  (req_cmd_i),
        .push_bank_i (req_bank_i),
        .pop_i       (found),
        .pop_idx_i   (sel_idx),
        .cnt_o       (q_cnt),
        .cmd_o       (q_cmd),
        .bank_o      (q_bank)
    );

    // ---------------- per-bank timing ----------------
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dct_bank_timer u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (do_issue && (sel_cmd == CMD_ACT) && (sel_bank == BW'(b))),
            .pre_i    (do_issue && (sel_cmd == CMD_PRE) && (sel_bank == BW'(b))),
            .trcd_i   (prof_q.trcd),
            .trp_i    (prof_q.trp),
            .open_o   (bank_open[b]),
            .col_ok_o (bank_col_ok[b]),
            .act_ok_o (bank_act_ok[b])
        );
    end

    // ---------------- eligibility of each queue entry ----------------
    always_comb begin
        for (int i = 0; i < QDEPTH; i++) begin
            blocked_v[i] = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (q_bank[j] == q_bank[i]) begin
                    blocked_v[i] = 1'b1;
                end
            end
            legal_v[i] = 1'b0;
            bad_v[i]   = 1'b0;
            unique case (dct_cmd_e'(q_cmd[i]))
                CMD_ACT: begin
                    legal_v[i] = bank_act_ok[q_bank[i]];
                    bad_v[i]   = bank_open[q_bank[i]];
                end
                CMD_RD, CMD_WR: begin
                    legal_v[i] = bank_col_ok[q_bank[i]];
                    bad_v[i]   = !bank_open[q_bank[i]];
                end
                CMD_PRE: begin
                    legal_v[i] = 1'b1;
                end
                default: begin
                    legal_v[i] = 1'b0;
                end
            endcase
            elig_v[i] = (state_q == ST_OPEN) && (CW'(i) < q_cnt) &&
                        !blocked_v[i] && (legal_v[i] || bad_v[i]);
        end
    end

    // Oldest eligible entry wins (entry 0 is oldest)
    always_comb begin
        found   = 1'b0;
        sel_idx = '0;
        for (int i = 0; i < QDEPTH; i++) begin
            if (!found && elig_v[i]) begin
                found   = 1'b1;
                sel_idx = IW'(i);
            end
        end
    end

    assign sel_cmd  = dct_cmd_e'(q_cmd[sel_idx]);
    assign sel_bank = q_bank[sel_idx];
    assign sel_rej  = bad_v[sel_idx];
    assign do_issue = found && !sel_rej;
    assign do_rej   = found && sel_rej;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CFG;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_CFG:  state_n = ST_OPEN;
            ST_OPEN: state_n = (do_issue && mode2n_q) ? ST_GAP : ST_OPEN;
            ST_GAP:  state_n = ST_OPEN;
            default: state_n = ST_CFG;
        endcase
    end

    // Configuration is captured only in ST_CFG
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prof_q   <= dct_profile(2'd0);
            mode2n_q <= 1'b0;
        end else if (state_q == ST_CFG) begin
            prof_q   <= dct_profile(cfg_profile_i);
            mode2n_q <= cfg_2n_i;
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid_o <= 1'b0;
            cmd_type_o  <= '0;
            cmd_bank_o  <= '0;
            rej_o       <= 1'b0;
        end else begin
            cmd_valid_o <= do_issue;
            cmd_type_o  <= do_issue ? sel_cmd : 2'd0;
            cmd_bank_o  <= do_issue ? sel_bank : '0;
            rej_o       <= do_rej;
        end
    end

    dct_lat_line #(
        .MAXL (MAX_LAT),
        .LW   (TW)
    ) u_rd_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (do_issue && (sel_cmd == CMD_RD)),
        .lat_i  (prof_q.tcl),
        .hit_o  (rd_data_valid_o)
    );

    dct_lat_line #(
        .MAXL (MAX_LAT),
        .LW   (TW)
    ) u_wr_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (do_issue && (sel_cmd == CMD_WR)),
        .lat_i  (prof_q.cwl),
        .hit_o  (wr_data_en_o)
    );

endmodule

// File: rtl/dct_checker.sv
module dct_checker
    import dct_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int QDEPTH    = 4,
    parameter int BW        = 2,
    parameter int CW        = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready_o,
    input logic          cmd_valid_o,
    input logic [1:0]    cmd_type_o,
    input logic [BW-1:0] cmd_bank_o,
    input logic          rej_o,
    input dct_state_e    state_q,
    input dct_prof_t     prof_q,
    input logic          mode2n_q,
    input logic [CW-1:0] q_cnt
);

    AST_CFG_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CFG) |-> !req_ready_o) else $error("ready during config"); // R1

    AST_LAUNCH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode2n_q && cmd_valid_o) |=> !cmd_valid_o) else $error("2N gap broken"); // R3

    AST_ISSUE_OR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid_o && rej_o)) else $error("strobe and reject together"); // R7

    AST_FULL_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cnt == CW'(QDEPTH)) |-> !req_ready_o) else $error("ready while full"); // R8

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_CFG) |=> ($stable(prof_q) && $stable(mode2n_q))) else $error("config moved"); // R10

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_spacing
        logic [5:0] since_act;
        logic [5:0] since_pre;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                since_act <= '1;
                since_pre <= '1;
            end else begin
                if (cmd_valid_o && (cmd_type_o == CMD_ACT) && (cmd_bank_o == BW'(b))) begin
                    since_act <= 6'd1;
                end else if (since_act != '1) begin
                    since_act <= since_act + 6'd1;
                end
                if (cmd_valid_o && (cmd_type_o == CMD_PRE) && (cmd_bank_o == BW'(b))) begin
                    since_pre <= 6'd1;
                end else if (since_pre != '1) begin
                    since_pre <= since_pre + 6'd1;
                end
            end
        end

        AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid_o && (cmd_bank_o == BW'(b)) &&
             ((cmd_type_o == CMD_RD) || (cmd_type_o == CMD_WR)))
            |-> (since_act >= {1'b0, prof_q.trcd})) else $error("tRCD violated"); // R4

        AST_RP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid_o && (cmd_bank_o == BW'(b)) && (cmd_type_o == CMD_ACT))
            |-> (since_pre >= {1'b0, prof_q.trp})) else $error("tRP violated"); // R5
    end

endmodule

bind dram_cmd_timer dct_checker #(
    .NUM_BANKS (NUM_BANKS),
    .QDEPTH    (QDEPTH),
    .BW        (BW),
    .CW        (CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready_o (req_ready_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_type_o  (cmd_type_o),
    .cmd_bank_o  (cmd_bank_o),
    .rej_o       (rej_o),
    .state_q     (state_q),
    .prof_q      (prof_q),
    .mode2n_q    (mode2n_q),
    .q_cnt       (q_cnt)
);

// File: tb/dram_cmd_timer_bench.sv
`timescale 1ns/1ps
module dram_cmd_timer_bench;

    localparam int NB = 4;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_profile_i = '0;
    logic          cfg_2n_i = 1'b0;
    logic          req_valid_i = 1'b0;
    logic          req_ready_o;
    logic [1:0]    req_cmd_i = '0;
    logic [BW-1:0] req_bank_i = '0;
    logic          cmd_valid_o;
    logic [1:0]    cmd_type_o;
    logic [BW-1:0] cmd_bank_o;
    logic          rej_o;
    logic          rd_data_valid_o;
    logic          wr_data_en_o;

    always #4 clk = ~clk;

    dram_cmd_timer #(.NUM_BANKS(NB), .QDEPTH(4), .MAX_LAT(16)) u_dram_cmd_timer (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_profile_i   (cfg_profile_i),
        .cfg_2n_i        (cfg_2n_i),
        .req_valid_i     (req_valid_i),
        .req_ready_o     (req_ready_o),
        .req_cmd_i       (req_cmd_i),
        .req_bank_i      (req_bank_i),
        .cmd_valid_o     (cmd_valid_o),
        .cmd_type_o      (cmd_type_o),
        .cmd_bank_o      (cmd_bank_o),
        .rej_o           (rej_o),
        .rd_data_valid_o (rd_data_valid_o),
        .wr_data_en_o    (wr_data_en_o)
    );

    int errors = 0;
    int checks = 0;

    // Event log filled at every falling edge
    int cyc = 0;
    int n_cmd, n_rd, n_wr, n_rej;
    int cmd_t [32];
    int cmd_b [32];
    int cmd_c [32];
    int rd_c  [32];
    int wr_c  [32];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cmd_valid_o && n_cmd < 32) begin
            cmd_t[n_cmd] = int'(cmd_type_o);
            cmd_b[n_cmd] = int'(cmd_bank_o);
            cmd_c[n_cmd] = cyc;
            n_cmd = n_cmd + 1;
        end
        if (rd_data_valid_o && n_rd < 32) begin
            rd_c[n_rd] = cyc;
            n_rd = n_rd + 1;
        end
        if (wr_data_en_o && n_wr < 32) begin
            wr_c[n_wr] = cyc;
            n_wr = n_wr + 1;
        end
        if (rej_o) n_rej = n_rej + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        n_cmd = 0; n_rd = 0; n_wr = 0; n_rej = 0;
    endtask

    task automatic apply_reset(input int sel, input int m2n);
        @(negedge clk);
        rst_n         = 1'b0;
        req_valid_i   = 1'b0;
        cfg_profile_i = 2'(sel);
        cfg_2n_i      = 1'(m2n);
        repeat (3) @(negedge clk);
        clear_log();
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Called at a falling edge; returns at the falling edge after acceptance
    task automatic push(input int c, input int b);
        req_valid_i = 1'b1;
        req_cmd_i   = 2'(c);
        req_bank_i  = BW'(b);
        while (!req_ready_o) @(negedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sel, 2N, tCL, tRCD, tRP, CWL
    localparam int VEC [8][6] = '{
        '{0, 0,  9,  9,  9, 7},
        '{1, 0, 11, 11, 11, 8},
        '{2, 0, 10, 12, 12, 7},
        '{3, 0, 12, 15, 15, 8},
        '{0, 1,  9,  9,  9, 7},
        '{1, 1, 11, 11, 11, 8},
        '{2, 1, 10, 12, 12, 7},
        '{3, 1, 12, 15, 15, 8}
    };

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        clear_log();

        // ---- reset state: R11, R1 ----
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!cmd_valid_o && !rej_o, "R11", "strobes in reset", int'(cmd_valid_o) + int'(rej_o), 0);
        check(!rd_data_valid_o && !wr_data_en_o, "R11", "markers in reset",
              int'(rd_data_valid_o) + int'(wr_data_en_o), 0);
        check(!req_ready_o, "R1", "ready in reset", int'(req_ready_o), 0);
        rst_n = 1'b1;
        check(!req_ready_o, "R1", "ready in config cycle", int'(req_ready_o), 0);
        @(negedge clk);
        check(req_ready_o, "R1", "ready after config", int'(req_ready_o), 1);

        // ---- vector table: R2 R3 R4 R5 R6 ----
        for (int v = 0; v < 8; v++) begin
            int gap;
            apply_reset(VEC[v][0], VEC[v][1]);
            push(0, 0); push(1, 0); push(2, 0); push(3, 0); push(0, 0);
            idle(70);
            gap = (VEC[v][1] != 0) ? 2 : 1;
            check(n_cmd == 5 && cmd_t[1] == 1 && cmd_t[2] == 2, "R2", "strobe count", n_cmd, 5);
            check(cmd_c[1] - cmd_c[0] == VEC[v][3], "R4", "ACT to RD", cmd_c[1] - cmd_c[0], VEC[v][3]);
            check(cmd_c[2] - cmd_c[1] == gap, "R3", "RD to WR", cmd_c[2] - cmd_c[1], gap);
            check(cmd_c[4] - cmd_c[3] == VEC[v][4], "R5", "PRE to ACT", cmd_c[4] - cmd_c[3], VEC[v][4]);
            check(n_rd == 1 && rd_c[0] - cmd_c[1] == VEC[v][2], "R6", "RD to data valid",
                  rd_c[0] - cmd_c[1], VEC[v][2]);
            check(n_wr == 1 && wr_c[0] - cmd_c[2] == VEC[v][5], "R6", "WR to write enable",
                  wr_c[0] - cmd_c[2], VEC[v][5]);
        end

        // ---- rejects: R7 ----
        apply_reset(0, 0);
        push(1, 2);
        idle(20);
        check(n_rej == 1, "R7", "RD closed bank reject", n_rej, 1);
        check(n_cmd == 0 && n_rd == 0, "R7", "RD closed bank strobes", n_cmd + n_rd, 0);
        push(0, 3); push(0, 3);
        idle(5);
        check(n_cmd == 1 && n_rej == 2, "R7", "ACT open bank reject", n_rej, 2);
        push(2, 1);
        idle(20);
        check(n_rej == 3 && n_wr == 0, "R7", "WR closed bank reject", n_rej, 3);

        // ---- ordering: R9 ----
        apply_reset(0, 0);
        push(0, 0); push(1, 0); push(0, 1);
        idle(30);
        check(n_cmd == 3, "R9", "strobe count", n_cmd, 3);
        check(cmd_t[1] == 0 && cmd_b[1] == 1, "R9", "second strobe is ACT bank1",
              cmd_t[1] * 10 + cmd_b[1], 1);
        check(cmd_t[2] == 1 && cmd_b[2] == 0, "R9", "third strobe is RD bank0",
              cmd_t[2] * 10 + cmd_b[2], 10);

        // ---- config frozen after ST_CFG: R10 ----
        apply_reset(0, 0);
        cfg_profile_i = 2'd3;
        cfg_2n_i      = 1'b1;
        push(0, 0); push(1, 0);
        idle(30);
        push(3, 1); push(3, 2);
        idle(10);
        check(n_cmd == 4, "R10", "strobe count", n_cmd, 4);
        check(cmd_c[1] - cmd_c[0] == 9, "R10", "tRCD unchanged", cmd_c[1] - cmd_c[0], 9);
        check(n_rd == 1 && rd_c[0] - cmd_c[1] == 9, "R10", "tCL unchanged", rd_c[0] - cmd_c[1], 9);
        check(cmd_c[3] - cmd_c[2] == 1, "R10", "launch mode unchanged", cmd_c[3] - cmd_c[2], 1);

        // ---- full queue: R8 ----
        apply_reset(3, 0);
        push(0, 0); push(1, 0); push(1, 0); push(1, 0); push(1, 0);
        check(!req_ready_o, "R8", "ready with full queue", int'(req_ready_o), 0);
        idle(60);
        check(n_cmd == 5 && n_rd == 4, "R8", "all queued reads issued", n_rd, 4);
        check(cmd_c[1] - cmd_c[0] == 15, "R4", "ACT to first RD", cmd_c[1] - cmd_c[0], 15);
        check(cmd_c[4] - cmd_c[1] == 3, "R3", "back-to-back reads", cmd_c[4] - cmd_c[1], 3);

        finish_run();
    end

endmodule